// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescer

This block holds a two-bit pending/queued (PQ) state for each of `NUM_SRC` interrupt sources. It coalesces repeated events, so that a source is reported downstream at most once until software acknowledges it. Software reaches the state through a memory-mapped window in which each source owns one 64 KiB page. The source index is `addr >> 16`. The operation is taken from address bits [11:8]. Address bits [15:12] and [7:0] are ignored.

A load performs end-of-interrupt, returns the current state, or forces a new state. Each load returns the state the source held before the access, and the read data is registered. A store at page offset zero is a trigger. A trigger that moves an idle source to pending raises a one-cycle notification pulse for that source, unless the source is masked. Configuration inputs mark each source as valid, masked, and level-type or message-type. For level-type sources the block also keeps a "sent" flag.

Top module: `irq_pq_coalescer`

## Requirements
- R1: After reset every source holds PQ = 01 (off), `notify` and `sentFlag` are all zero, and `rdValid` is low. P is bit 1 and Q is bit 0.
- R2: A valid store at offset 0x000 (a trigger) moves PQ 00→10, 10→11 and 11→11. It leaves 01 unchanged.
- R3: `notify[i]` is high for exactly the one cycle after a trigger that moves source i from 00 to 10 while the source is unmasked. No other trigger produces a pulse.
- R4: A trigger to a masked source still updates PQ as in R2, and it produces no pulse.
- R5: A load at offset 0x000 (end-of-interrupt) moves 11→10 and returns 1 in `rdData`. It moves 10→00 and returns 0. It leaves 00 and 01 unchanged and returns 0.
- R6: A load at offset 0x800 returns PQ in `rdData[1:0]` with all upper bits zero, and it does not change the state.
- R7: A load at offsets 0xC00, 0xD00, 0xE00 or 0xF00 sets PQ to address bits [9:8] (00, 01, 10 or 11) and returns the previous PQ.
- R8: Certain loads return all ones and change no state. These are loads to a source not marked valid, loads whose size code (log2 of bytes) is not 3, and loads to any other offset. Stores to a nonzero offset, stores with a wrong size, and stores to an invalid source change no state and produce no pulse.
- R9: For a level-type source, a notification pulse sets `sentFlag[i]` and an end-of-interrupt clears it. A message-type source never sets its flag.
- R10: When a store and a load reach the same source in one cycle, the store is applied first. The load then operates on, and returns, the state that the trigger produced.
- R11: `rdValid` is high for exactly the one cycle after each load, including rejected loads. `rdData` is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Load request |
| ldAddr | input | ADDR_W | Load byte address |
| ldSize | input | 2 | Load size code, log2 of bytes (3 = 8 bytes) |
| stValid | input | 1 | Store request |
| stAddr | input | ADDR_W | Store byte address |
| stSize | input | 2 | Store size code, log2 of bytes |
| srcValid | input | NUM_SRC | Per-source valid configuration |
| srcMask | input | NUM_SRC | Per-source mask configuration |
| srcLevel | input | NUM_SRC | Per-source level-type flag |
| rdValid | output | 1 | Load response valid |
| rdData | output | 64 | Load response, big-endian (value in the low bits, last byte) |
| notify | output | NUM_SRC | One-cycle notification pulse per source |
| sentFlag | output | NUM_SRC | Sent status for level-type sources |

## Verification
On every cycle, the assertions check the following:
- notification pulses are at most one-hot;
- every pulse follows a trigger to a source that was idle and unmasked;
- every load is answered one cycle later;
- a sent flag only rises on a level-type source.

The state transitions can only be shown by the directed scenarios, which compare read-back values with a model of the state machine. These cover the previous-state return values, the end-of-interrupt retrigger result, the force operations, the rejected accesses, and the store-before-load ordering within one cycle.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_OFF    = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_QUEUED = 2'b11;

  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic stTrig;
    logic ldAny;
    logic ldBad;
    logic ldEoi;
    logic ldGet;
    logic ldForce;
    pq_t  forceVal;
  } strobe_t;

  function automatic pq_t trigNext(pq_t s);
    case (s)
      PQ_IDLE: return PQ_PEND;
      PQ_PEND: return PQ_QUEUED;
      PQ_QUEUED: return PQ_QUEUED;
      default: return s;
    endcase
  endfunction

  function automatic pq_t eoiNext(pq_t s);
    case (s)
      PQ_QUEUED: return PQ_PEND;
      PQ_PEND: return PQ_IDLE;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int IDX_W      = 3,
  parameter int PAGE_SHIFT = 16,
  parameter int ADDR_W     = PAGE_SHIFT + IDX_W
) (
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [NUM_SRC-1:0] srcValid,
  output strobe_t           strobe,
  output logic [IDX_W-1:0]  ldIdx,
  output logic [IDX_W-1:0]  stIdx
);
  localparam logic [1:0] SIZE_8B = 2'd3;

  logic [3:0] ldOff, stOff;
  logic ldHit, stHit;

  assign ldIdx = ldAddr[PAGE_SHIFT +: IDX_W];
  assign stIdx = stAddr[PAGE_SHIFT +: IDX_W];
  assign ldOff = ldAddr[11:8];
  assign stOff = stAddr[11:8];

  always_comb begin
    ldHit = ldValid && (ldSize == SIZE_8B) && (int'(ldIdx) < NUM_SRC) && srcValid[ldIdx];
    stHit = stValid && (stSize == SIZE_8B) && (int'(stIdx) < NUM_SRC) && srcValid[stIdx];

    strobe          = '0;
    strobe.ldAny    = ldValid;
    strobe.ldEoi    = ldHit && (ldOff == 4'h0);
    strobe.ldGet    = ldHit && (ldOff == 4'h8);
    strobe.ldForce  = ldHit && (ldOff[3:2] == 2'b11);
    strobe.forceVal = ldOff[1:0];
    strobe.ldBad    = ldValid && !(strobe.ldEoi || strobe.ldGet || strobe.ldForce);
    strobe.stTrig   = stHit && (stOff == 4'h0);
  end
endmodule

// File: rtl/pq_state.sv
module pq_state
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [IDX_W-1:0]   ldIdx,
  input  logic [IDX_W-1:0]   stIdx,
  input  logic [NUM_SRC-1:0] srcMask,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               rdValid,
  output logic [63:0]        rdData,
  output logic [NUM_SRC-1:0] notify,
  output logic [NUM_SRC-1:0] sentFlag
);
  pq_t [NUM_SRC-1:0] pq, pqMid, pqNext;
  logic [NUM_SRC-1:0] notifyNext, sentNext;
  logic [63:0] rdNext;
  pq_t trigOld, ldCur;

  always_comb begin
    pqMid      = pq;
    notifyNext = '0;
    trigOld    = pq[stIdx];
    // store is applied first so a same-cycle load sees its result
    if (strobe.stTrig) begin
      pqMid[stIdx] = trigNext(trigOld);
      if (trigOld == PQ_IDLE && !srcMask[stIdx]) notifyNext[stIdx] = 1'b1;
    end

    pqNext   = pqMid;
    sentNext = sentFlag | (notifyNext & srcLevel);
    rdNext   = '1;
    ldCur    = pqMid[ldIdx];
    if (strobe.ldEoi) begin
      pqNext[ldIdx] = eoiNext(ldCur);
      rdNext        = {63'b0, ldCur == PQ_QUEUED};
      if (srcLevel[ldIdx]) sentNext[ldIdx] = 1'b0;
    end else if (strobe.ldGet) begin
      rdNext = {62'b0, ldCur};
    end else if (strobe.ldForce) begin
      pqNext[ldIdx] = strobe.forceVal;
      rdNext        = {62'b0, ldCur};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pq       <= {NUM_SRC{PQ_OFF}};
      notify   <= '0;
      sentFlag <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
    end else begin
      pq       <= pqNext;
      notify   <= notifyNext;
      sentFlag <= sentNext;
      rdValid  <= strobe.ldAny;
      if (strobe.ldAny) rdData <= rdNext;
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(notify));

  a_r3_pulse_needs_trigger: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stTrig == 1'b0 |=> notify == '0);

  a_r11_load_answered: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldAny |=> rdValid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldAny |=> !rdValid);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    a_r4_masked_silent: assert property (@(posedge clk) disable iff (!rstN)
      srcMask[i] |=> !notify[i]);
    a_r3_from_idle: assert property (@(posedge clk) disable iff (!rstN)
      pq[i] != PQ_IDLE |=> !notify[i]);
    a_r9_level_only: assert property (@(posedge clk) disable iff (!rstN)
      !srcLevel[i] && !sentFlag[i] |=> !sentFlag[i]);
  end
endmodule

// File: rtl/irq_pq_coalescer.sv
module irq_pq_coalescer
  import pq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 16,
  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W    = PAGE_SHIFT + IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ldValid,
  input  logic [ADDR_W-1:0]  ldAddr,
  input  logic [1:0]         ldSize,
  input  logic               stValid,
  input  logic [ADDR_W-1:0]  stAddr,
  input  logic [1:0]         stSize,
  input  logic [NUM_SRC-1:0] srcValid,
  input  logic [NUM_SRC-1:0] srcMask,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               rdValid,
  output logic [63:0]        rdData,
  output logic [NUM_SRC-1:0] notify,
  output logic [NUM_SRC-1:0] sentFlag
);
  strobe_t strobe;
  logic [IDX_W-1:0] ldIdx, stIdx;

  pq_decode #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .ADDR_W(ADDR_W)
  ) u_decode (
    .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .srcValid(srcValid), .strobe(strobe), .ldIdx(ldIdx), .stIdx(stIdx)
  );

  pq_state #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ldIdx(ldIdx), .stIdx(stIdx),
    .srcMask(srcMask), .srcLevel(srcLevel), .rdValid(rdValid),
    .rdData(rdData), .notify(notify), .sentFlag(sentFlag)
  );
endmodule

// File: tb/irq_pq_coalescer_tb.sv
module irq_pq_coalescer_tb;
  localparam int NS = 8;
  localparam int AW = 19;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0, stValid = 1'b0;
  logic [AW-1:0] ldAddr = '0, stAddr = '0;
  logic [1:0] ldSize = 2'd3, stSize = 2'd3;
  logic [NS-1:0] srcValid = 8'b0111_1111;
  logic [NS-1:0] srcMask  = 8'b0010_0000;
  logic [NS-1:0] srcLevel = 8'b0000_1100;
  logic rdValid;
  logic [63:0] rdData;
  logic [NS-1:0] notify, sentFlag;

  int errors = 0, checks = 0;
  logic done = 1'b0;
  logic cRdV; logic [63:0] cRdD; logic [NS-1:0] cNt, cSn;

  always #2.5 clk = ~clk;

  irq_pq_coalescer u_dut (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize), .srcValid(srcValid),
    .srcMask(srcMask), .srcLevel(srcLevel), .rdValid(rdValid), .rdData(rdData),
    .notify(notify), .sentFlag(sentFlag)
  );

  function automatic logic [AW-1:0] mkA(int idx, int off);
    return AW'((idx << 16) | off);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic le, logic [AW-1:0] la, logic [1:0] ls,
                     logic se, logic [AW-1:0] sa, logic [1:0] ss);
    @(negedge clk);
    ldValid = le; ldAddr = la; ldSize = ls;
    stValid = se; stAddr = sa; stSize = ss;
    @(negedge clk);
    cRdV = rdValid; cRdD = rdData; cNt = notify; cSn = sentFlag;
    ldValid = 1'b0; stValid = 1'b0; ldSize = 2'd3; stSize = 2'd3;
  endtask

  task automatic load(int idx, int off);
    cyc(1'b1, mkA(idx, off), 2'd3, 1'b0, '0, 2'd3);
  endtask

  task automatic store(int idx, int off);
    cyc(1'b0, '0, 2'd3, 1'b1, mkA(idx, off), 2'd3);
  endtask

  task automatic t_reset;
    chk("R1 rdValid", 64'(rdValid), 0);
    chk("R1 notify", 64'(notify), 0);
    chk("R1 sentFlag", 64'(sentFlag), 0);
    for (int i = 0; i < 7; i++) begin
      load(i, 'h800);
      chk("R1 pq off", cRdD, 64'h1);
    end
  endtask

  task automatic t_trigger;
    load(0, 'hC00); chk("R7 force00 prev", cRdD, 1);
    store(0, 0);    chk("R3 pulse 00->10", 64'(cNt), 64'h01);
    load(0, 'h800); chk("R2 00->10", cRdD, 2);
    chk("R3 pulse one cycle", 64'(cNt), 0);
    store(0, 0);    chk("R3 no pulse 10->11", 64'(cNt), 0);
    load(0, 'h800); chk("R2 10->11", cRdD, 3);
    store(0, 0);    chk("R3 no pulse 11", 64'(cNt), 0);
    load(0, 'h800); chk("R2 11 stays", cRdD, 3);
    store(1, 0);    chk("R3 no pulse off", 64'(cNt), 0);
    load(1, 'h800); chk("R2 off stays", cRdD, 1);
  endtask

  task automatic t_eoi;
    load(0, 0);     chk("R5 eoi 11 returns 1", cRdD, 1);
    load(0, 'h800); chk("R5 11->10", cRdD, 2);
    load(0, 0);     chk("R5 eoi 10 returns 0", cRdD, 0);
    load(0, 'h800); chk("R5 10->00", cRdD, 0);
    load(0, 0);     chk("R5 eoi 00 returns 0", cRdD, 0);
    load(0, 'h800); chk("R5 00 stays", cRdD, 0);
    load(1, 0);     chk("R5 eoi off returns 0", cRdD, 0);
    load(1, 'h800); chk("R6 get no change", cRdD, 1);
  endtask

  task automatic t_force;
    load(4, 'hF00); chk("R7 force11 prev 01", cRdD, 1);
    load(4, 'hE00); chk("R7 force10 prev 11", cRdD, 3);
    load(4, 'hD00); chk("R7 force01 prev 10", cRdD, 2);
    load(4, 'hC00); chk("R7 force00 prev 01", cRdD, 1);
    load(4, 'h800); chk("R7 final 00", cRdD, 0);
  endtask

  task automatic t_mask;
    load(5, 'hC00);
    store(5, 0);    chk("R4 masked no pulse", 64'(cNt), 0);
    load(5, 'h800); chk("R4 masked still 10", cRdD, 2);
  endtask

  task automatic t_invalid;
    load(7, 'h800); chk("R8 invalid src ones", cRdD, ONES);
    store(7, 0);    chk("R8 invalid store no pulse", 64'(cNt), 0);
    load(0, 'h400); chk("R8 bad offset ones", cRdD, ONES);
    load(0, 'h800); chk("R8 bad offset no change", cRdD, 0);
    store(0, 'h800); chk("R8 store offset no pulse", 64'(cNt), 0);
    load(0, 'h800); chk("R8 store offset no change", cRdD, 0);
    cyc(1'b1, mkA(0, 'hE00), 2'd2, 1'b0, '0, 2'd3);
    chk("R8 bad size ones", cRdD, ONES);
    cyc(1'b0, '0, 2'd3, 1'b1, mkA(0, 0), 2'd2);
    chk("R8 bad size store no pulse", 64'(cNt), 0);
    load(0, 'h800); chk("R8 bad size no change", cRdD, 0);
  endtask

  task automatic t_level;
    load(2, 'hC00);
    store(2, 0);
    chk("R9 level pulse", 64'(cNt), 64'h04);
    chk("R9 sent set", 64'(cSn), 64'h04);
    load(2, 0);     chk("R9 sent cleared", 64'(cSn), 0);
    store(0, 0);    chk("R9 message pulse", 64'(cNt), 64'h01);
    chk("R9 message no sent", 64'(cSn), 0);
    load(0, 'hC00);
  endtask

  task automatic t_same;
    load(3, 'hC00);
    cyc(1'b1, mkA(3, 'h800), 2'd3, 1'b1, mkA(3, 0), 2'd3);
    chk("R10 load sees trigger", cRdD, 2);
    chk("R10 pulse", 64'(cNt), 64'h08);
    cyc(1'b1, mkA(3, 0), 2'd3, 1'b1, mkA(3, 0), 2'd3);
    chk("R10 eoi after trigger", cRdD, 1);
    load(3, 'h800); chk("R10 final 10", cRdD, 2);
  endtask

  task automatic t_rdvalid;
    load(6, 'h800);
    chk("R11 valid after load", 64'(cRdV), 1);
    @(negedge clk);
    chk("R11 valid one cycle", 64'(rdValid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_eoi();
    t_force();
    t_mask();
    t_invalid();
    t_level();
    t_same();
    t_rdvalid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule